// File: doc/BRIEF.md
# Reset, sleep and wake sequencer

This block decides when a small 8-bit processor core is reset, when it is frozen in low-power sleep, and which value its program counter takes when it comes back. It watches an external reset pin, a watchdog timeout pulse, an external interrupt request and three instruction-side strobes (sleep, reset, stack push/pop). It turns them into a one-cycle core reset, a core hold level that gates the core clock, and a program-counter load strobe with its value. A 31-entry return-address stack lives inside the block, because pushing onto a full stack or popping an empty one has to restart the core. Six sticky cause flags record why the last reset or watchdog wake happened.

The watchdog has two meanings. While the core runs, a timeout restarts the program at address zero. While the core sleeps, a timeout only wakes it, and execution goes on two bytes past the program-counter value saved when the sleep instruction executed. The block is built around a five-state machine: RUN, RESET (core reset high), VECTOR (load PC with zero), SLEEP (core held) and RESUME (load saved PC plus two). Its transitions are: RUN to RESET on any reset event; RUN to SLEEP on the sleep strobe; SLEEP to RESET on the external reset; SLEEP to RESUME on a watchdog timeout or an interrupt; RESET to VECTOR always; and VECTOR and RESUME to RUN always.

Top module: `pwr_rst_seq`

## Requirements
- R1: After `rst_n` is released, the state is RUN: core reset, hold and PC load are low, all cause flags are 0 and the stack is empty (empty flag 1, pop data 0).
- R2: An external reset in RUN raises `core_rst_o` in the next cycle for exactly one cycle. In the cycle after that, `pc_load_o` is 1 with `pc_val_o` = 0. The stack is empty by that PC-load cycle. Cause bit 0 (external) is set.
- R3: A watchdog timeout in RUN causes the same reset and zero load as R2, and sets cause bit 1 (watchdog reset).
- R4: A reset-instruction strobe in RUN causes the same reset and zero load as R2, and sets cause bit 3 (instruction).
- R5: The stack is last-in first-out and 21 bits wide. `pop_data_o` shows the top entry (0 when empty). `stk_full_o` is 1 at 31 entries and `stk_empty_o` is 1 at zero entries. When push and pop arrive together, the push wins.
- R6: A push while the stack holds 31 entries causes the R2 reset sequence and sets cause bit 4 (stack full). The entry is not stored.
- R7: A pop without a push while the stack is empty causes the R2 reset sequence and sets cause bit 5 (underflow).
- R8: A sleep strobe in RUN saves `cur_pc_i` and raises `core_hold_o` from the next cycle onward. Hold stays high until a wake or reset.
- R9: A watchdog timeout in SLEEP gives no core reset. In the next cycle, hold drops and `pc_load_o` is 1 with `pc_val_o` = saved PC + 2 (modulo 2^21). Cause bit 2 (watchdog wake) is set.
- R10: An interrupt in SLEEP wakes the core as in R9 but sets no cause flag.
- R11: An external reset in SLEEP ends sleep with the full R2 sequence, including clearing the stack, and sets cause bit 0.
- R12: In SLEEP, the sleep, reset-instruction, push and pop strobes have no effect. Hold stays high and the stack is unchanged.
- R13: When several events arrive in the same RUN cycle, the priority is: external reset, watchdog, reset instruction, stack full, underflow, sleep, then push/pop. Only the winner takes effect.
- R14: Cause flags are sticky. Writing a 1 to bit i of `cause_clr_i` clears flag i in the next cycle. A flag that is set and cleared in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| ext_rst_i | input | 1 | External reset request, synchronous level |
| wdt_to_i | input | 1 | Watchdog timeout pulse |
| ext_irq_i | input | 1 | External interrupt request |
| sleep_i | input | 1 | Sleep instruction strobe |
| rst_instr_i | input | 1 | Reset instruction strobe |
| push_i | input | 1 | Return-address push strobe |
| pop_i | input | 1 | Return-address pop strobe |
| push_data_i | input | 21 | Address to push |
| cur_pc_i | input | 21 | PC of the instruction currently executing |
| cause_clr_i | input | 6 | Write-one-to-clear mask for cause flags |
| core_rst_o | output | 1 | Core reset, one cycle per reset event |
| core_hold_o | output | 1 | Core clock-gate hold while sleeping |
| pc_load_o | output | 1 | Program-counter load strobe |
| pc_val_o | output | 21 | Program-counter load value |
| cause_o | output | 6 | Sticky reset/wake cause flags |
| pop_data_o | output | 21 | Top of the return-address stack |
| stk_full_o | output | 1 | Stack holds 31 entries |
| stk_empty_o | output | 1 | Stack holds no entries |

## Verification
The watchdog pulse is applied in both RUN and SLEEP. This shows whether the design picks a zero restart or a resume at the saved PC plus two, and a saved PC of 0x1FFFFF checks that the addition wraps. Sleep is ended in turn by the watchdog, the interrupt and the external reset. In between, sleep, reset-instruction, push and pop strobes are sent while the core is held, which separates real wake sources from ignored ones. Simultaneous event pairs in RUN check the priority order. Filling the stack to 31 entries and popping an empty one covers both stack-fault resets. A clear and a set of the same cause flag in one cycle checks which one wins.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_RESET,
        ST_VECTOR,
        ST_SLEEP,
        ST_RESUME
    } seq_state_e;

    localparam int CAUSE_N     = 6;
    localparam int CB_EXT      = 0;
    localparam int CB_WDT      = 1;
    localparam int CB_WDT_WAKE = 2;
    localparam int CB_INSTR    = 3;
    localparam int CB_FULL     = 4;
    localparam int CB_UNDER    = 5;
endpackage

// File: rtl/rsq_stack.sv
module rsq_stack #(
    parameter int W     = 21,
    parameter int DEPTH = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] ptr;
    logic [W-1:0]     mem [DEPTH];
    logic             wr_en;
    logic             rd_en;

    assign full  = (ptr == PTR_W'(DEPTH));
    assign empty = (ptr == '0);
    assign wr_en = push && !full;
    assign rd_en = pop && !push && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr <= '0;
        else if (clr)   ptr <= '0;
        else if (wr_en) ptr <= ptr + 1'b1;
        else if (rd_en) ptr <= ptr - 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!clr && wr_en && ptr == PTR_W'(i)) mem[i] <= din;
        end
    end

    assign dout = empty ? '0 : mem[ptr - 1'b1];
endmodule

// File: rtl/rsq_cause.sv
module rsq_cause #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_rst,
    input  logic               wdt_to,
    input  logic               irq,
    input  logic               sleep_req,
    input  logic               rst_instr,
    input  logic               push,
    input  logic               pop,
    input  logic               stk_full,
    input  logic               stk_empty,
    input  logic [PC_W-1:0]    cur_pc,
    output logic               stk_push,
    output logic               stk_pop,
    output logic               stk_clr,
    output logic [CAUSE_N-1:0] cause_set,
    output logic               core_rst,
    output logic               core_hold,
    output logic               pc_load,
    output logic [PC_W-1:0]    pc_val
);
    seq_state_e      state, nxt;
    logic [PC_W-1:0] saved_pc;
    logic            save_pc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       saved_pc <= '0;
        else if (save_pc) saved_pc <= cur_pc;
    end

    always_comb begin
        nxt       = state;
        cause_set = '0;
        save_pc   = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (ext_rst) begin
                    nxt = ST_RESET; cause_set[CB_EXT] = 1'b1;
                end else if (wdt_to) begin
                    nxt = ST_RESET; cause_set[CB_WDT] = 1'b1;
                end else if (rst_instr) begin
                    nxt = ST_RESET; cause_set[CB_INSTR] = 1'b1;
                end else if (push && stk_full) begin
                    nxt = ST_RESET; cause_set[CB_FULL] = 1'b1;
                end else if (pop && !push && stk_empty) begin
                    nxt = ST_RESET; cause_set[CB_UNDER] = 1'b1;
                end else if (sleep_req) begin
                    nxt = ST_SLEEP; save_pc = 1'b1;
                end else begin
                    stk_push = push;
                    stk_pop  = pop;
                end
            end
            ST_RESET:  nxt = ST_VECTOR;
            ST_VECTOR: nxt = ST_RUN;
            ST_RESUME: nxt = ST_RUN;
            ST_SLEEP: begin
                if (ext_rst) begin
                    nxt = ST_RESET; cause_set[CB_EXT] = 1'b1;
                end else if (wdt_to) begin
                    nxt = ST_RESUME; cause_set[CB_WDT_WAKE] = 1'b1;
                end else if (irq) begin
                    nxt = ST_RESUME;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        core_rst  = (state == ST_RESET);
        core_hold = (state == ST_SLEEP);
        pc_load   = (state == ST_VECTOR) || (state == ST_RESUME);
        pc_val    = (state == ST_RESUME) ? saved_pc + PC_W'(2) : '0;
        stk_clr   = (state == ST_RESET);
    end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
    import rsq_pkg::*;
#(
    parameter int PC_W      = 21,
    parameter int STK_DEPTH = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_rst_i,
    input  logic               wdt_to_i,
    input  logic               ext_irq_i,
    input  logic               sleep_i,
    input  logic               rst_instr_i,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [PC_W-1:0]    push_data_i,
    input  logic [PC_W-1:0]    cur_pc_i,
    input  logic [CAUSE_N-1:0] cause_clr_i,
    output logic               core_rst_o,
    output logic               core_hold_o,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_val_o,
    output logic [CAUSE_N-1:0] cause_o,
    output logic [PC_W-1:0]    pop_data_o,
    output logic               stk_full_o,
    output logic               stk_empty_o
);
    logic               stk_push, stk_pop, stk_clr;
    logic [CAUSE_N-1:0] cause_set;

    rsq_fsm #(.PC_W(PC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ext_rst(ext_rst_i), .wdt_to(wdt_to_i), .irq(ext_irq_i),
        .sleep_req(sleep_i), .rst_instr(rst_instr_i),
        .push(push_i), .pop(pop_i),
        .stk_full(stk_full_o), .stk_empty(stk_empty_o),
        .cur_pc(cur_pc_i),
        .stk_push(stk_push), .stk_pop(stk_pop), .stk_clr(stk_clr),
        .cause_set(cause_set),
        .core_rst(core_rst_o), .core_hold(core_hold_o),
        .pc_load(pc_load_o), .pc_val(pc_val_o)
    );

    rsq_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .clr(stk_clr),
        .push(stk_push), .pop(stk_pop), .din(push_data_i),
        .dout(pop_data_o), .full(stk_full_o), .empty(stk_empty_o)
    );

    rsq_cause #(.N(CAUSE_N)) u_cause (
        .clk(clk), .rst_n(rst_n), .set(cause_set),
        .clr(cause_clr_i), .flags(cause_o)
    );
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk #(
    parameter int PC_W = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_rst_i,
    input logic            wdt_to_i,
    input logic            ext_irq_i,
    input logic            core_rst_o,
    input logic            core_hold_o,
    input logic            pc_load_o,
    input logic [PC_W-1:0] pc_val_o,
    input logic            stk_full_o,
    input logic            stk_empty_o
);
    logic running;
    assign running = !core_rst_o && !core_hold_o && !pc_load_o;

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o); // R2

    AST_ZERO_LOAD_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> (pc_load_o && pc_val_o == '0 && stk_empty_o)); // R2

    AST_WDT_RUN_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wdt_to_i) |=> core_rst_o); // R3

    AST_WDT_SLEEP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold_o && wdt_to_i && !ext_rst_i) |=> (pc_load_o && !core_rst_o && !core_hold_o)); // R9

    AST_IRQ_SLEEP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold_o && ext_irq_i && !ext_rst_i) |=> (pc_load_o && !core_rst_o)); // R10

    AST_SLEEP_EXT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold_o && ext_rst_i) |=> core_rst_o); // R11

    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold_o && !ext_rst_i && !wdt_to_i && !ext_irq_i) |=> core_hold_o); // R12

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_rst_o, core_hold_o, pc_load_o})); // R8

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_full_o && stk_empty_o)); // R5
endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i), .wdt_to_i(wdt_to_i),
    .ext_irq_i(ext_irq_i), .core_rst_o(core_rst_o), .core_hold_o(core_hold_o),
    .pc_load_o(pc_load_o), .pc_val_o(pc_val_o),
    .stk_full_o(stk_full_o), .stk_empty_o(stk_empty_o)
);

// File: tb/tb_pwr_rst_seq.sv
module tb_pwr_rst_seq;
    localparam int PC_W = 21;
    localparam int DEPTH = 31;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext_rst_i = 0, wdt_to_i = 0, ext_irq_i = 0, sleep_i = 0;
    logic            rst_instr_i = 0, push_i = 0, pop_i = 0;
    logic [PC_W-1:0] push_data_i = '0, cur_pc_i = '0;
    logic [5:0]      cause_clr_i = '0;
    logic            core_rst_o, core_hold_o, pc_load_o, stk_full_o, stk_empty_o;
    logic [PC_W-1:0] pc_val_o, pop_data_o;
    logic [5:0]      cause_o;

    always #4 clk = ~clk;

    pwr_rst_seq dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i), .wdt_to_i(wdt_to_i),
        .ext_irq_i(ext_irq_i), .sleep_i(sleep_i), .rst_instr_i(rst_instr_i),
        .push_i(push_i), .pop_i(pop_i), .push_data_i(push_data_i),
        .cur_pc_i(cur_pc_i), .cause_clr_i(cause_clr_i),
        .core_rst_o(core_rst_o), .core_hold_o(core_hold_o), .pc_load_o(pc_load_o),
        .pc_val_o(pc_val_o), .cause_o(cause_o), .pop_data_o(pop_data_o),
        .stk_full_o(stk_full_o), .stk_empty_o(stk_empty_o)
    );

    // behavioural model: 0 run, 1 reset, 2 vector, 3 sleep, 4 resume
    int              m_st;
    logic [5:0]      m_cause;
    logic [PC_W-1:0] m_saved;
    logic [PC_W-1:0] q[$];
    logic [5:0]      setv;
    int              nst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cause = '0; m_saved = '0; q.delete();
        end else begin
            setv = '0; nst = m_st;
            case (m_st)
                0: begin
                    if (ext_rst_i) begin setv[0] = 1; nst = 1; end
                    else if (wdt_to_i) begin setv[1] = 1; nst = 1; end
                    else if (rst_instr_i) begin setv[3] = 1; nst = 1; end
                    else if (push_i && q.size() == DEPTH) begin setv[4] = 1; nst = 1; end
                    else if (pop_i && !push_i && q.size() == 0) begin setv[5] = 1; nst = 1; end
                    else if (sleep_i) begin m_saved = cur_pc_i; nst = 3; end
                    else if (push_i) q.push_back(push_data_i);
                    else if (pop_i) void'(q.pop_back());
                end
                1: begin q.delete(); nst = 2; end
                2, 4: nst = 0;
                3: begin
                    if (ext_rst_i) begin setv[0] = 1; nst = 1; end
                    else if (wdt_to_i) begin setv[2] = 1; nst = 4; end
                    else if (ext_irq_i) nst = 4;
                end
                default: nst = 0;
            endcase
            m_cause = (m_cause & ~cause_clr_i) | setv;
            m_st = nst;
        end
    end

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [PC_W-1:0] exp_pc;
        exp_pc = (m_st == 4) ? m_saved + PC_W'(2) : '0;
        chk("core_rst", 32'(core_rst_o), 32'(m_st == 1));
        chk("core_hold", 32'(core_hold_o), 32'(m_st == 3));
        chk("pc_load", 32'(pc_load_o), 32'(m_st == 2 || m_st == 4));
        chk("pc_val", 32'(pc_val_o), 32'(exp_pc));
        chk("cause", 32'(cause_o), 32'(m_cause));
        chk("pop_data", 32'(pop_data_o), 32'(q.size() == 0 ? '0 : q[$]));
        chk("full", 32'(stk_full_o), 32'(q.size() == DEPTH));
        chk("empty", 32'(stk_empty_o), 32'(q.size() == 0));
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        ext_rst_i = 0; wdt_to_i = 0; ext_irq_i = 0; sleep_i = 0;
        rst_instr_i = 0; push_i = 0; pop_i = 0; cause_clr_i = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_push(input logic [PC_W-1:0] v);
        push_i = 1; push_data_i = v; tick();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1"; tick(); idle(1);

        cur_req = "R5";
        do_push(21'h0ABCDE); do_push(21'h000123); do_push(21'h1FFFF0);
        pop_i = 1; tick();
        push_i = 1; pop_i = 1; push_data_i = 21'h055555; tick();
        pop_i = 1; tick(); idle(1);

        cur_req = "R2"; ext_rst_i = 1; tick(); idle(3);
        cur_req = "R3"; do_push(21'h000042); wdt_to_i = 1; tick(); idle(3);
        cur_req = "R4"; rst_instr_i = 1; tick(); idle(3);

        cur_req = "R6";
        for (int i = 0; i < DEPTH; i++) do_push(PC_W'(i * 7 + 3));
        do_push(21'h1DEAD0); idle(3);

        cur_req = "R7"; pop_i = 1; tick(); idle(3);

        cur_req = "R8"; do_push(21'h000777); cur_pc_i = 21'h001234; sleep_i = 1; tick(); idle(2);
        cur_req = "R12";
        sleep_i = 1; tick(); rst_instr_i = 1; tick();
        do_push(21'h000999); pop_i = 1; tick(); idle(1);
        cur_req = "R9"; wdt_to_i = 1; tick(); idle(2);

        cur_req = "R10"; cur_pc_i = 21'h1FFFFF; sleep_i = 1; tick(); idle(1);
        ext_irq_i = 1; tick(); idle(2);

        cur_req = "R9"; cur_pc_i = 21'h0000FE; sleep_i = 1; tick();
        wdt_to_i = 1; ext_irq_i = 1; tick(); idle(2);

        cur_req = "R11"; sleep_i = 1; tick(); idle(1); ext_rst_i = 1; tick(); idle(3);

        cur_req = "R13";
        ext_rst_i = 1; wdt_to_i = 1; rst_instr_i = 1; tick(); idle(3);
        wdt_to_i = 1; rst_instr_i = 1; tick(); idle(3);
        push_i = 1; sleep_i = 1; cur_pc_i = 21'h000010; tick(); ext_irq_i = 1; tick(); idle(2);
        pop_i = 1; sleep_i = 1; tick(); idle(3);

        cur_req = "R14";
        cause_clr_i = 6'b000011; tick();
        cause_clr_i = 6'b001000; rst_instr_i = 1; tick(); idle(3);
        cause_clr_i = 6'b111111; tick(); idle(2);

        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            report();
        end
    end
endmodule